// File: doc/BRIEF.md
# DMA Channel Event Trigger Controller

This block is the event-control slice of a single DMA channel. It holds one 32-bit control word on a simple write/read register bus. It also watches a stream of interrupt events, each a one-cycle valid strobe carrying an 8-bit interrupt number. From those events, from two write-one software strobes, and from a pattern-match indication sent by the datapath, it issues single-cycle start and abort requests to the channel's transfer engine. When a pattern-match abort fires, it also asks for the channel enable to be cleared, and it keeps a sticky abort flag for interrupt-driven aborts.

Two 8-bit selectors pick which interrupt number starts a transfer and which one aborts it. Each selector has its own enable bit. A third enable arms the pattern-match abort. Any abort condition beats a start condition raised in the same cycle. A start is issued only while the channel is enabled and the engine is idle. A start that cannot be issued is discarded, not held for later. Every output is taken straight from a flop, so each response appears on the clock edge that follows the cause.

Top module: `dma_evt_ctrl`

## Requirements
- R1: After synchronous reset the read word is 0x00FF_FF00 (both selectors 0xFF, all enables 0), and xfer_start, xfer_abort, en_clr_req and abort_flag are 0.
- R2: Field layout of the control word: bits 23:16 are the abort interrupt selector, bits 15:8 are the start interrupt selector, bit 5 is the pattern-abort enable, bit 4 is the start-interrupt enable, bit 3 is the abort-interrupt enable. Bits 31:24 and 2:0 ignore writes and read 0.
- R3: A write with bit 7 set makes xfer_start high for exactly the one cycle after the write edge, provided ch_en is 1, eng_busy is 0 and no abort condition is present. Bit 7 always reads 0.
- R4: A write with bit 6 set makes xfer_abort high for exactly the one cycle after the write edge, whatever the engine state. Bit 6 always reads 0, and this abort leaves abort_flag unchanged.
- R5: An event whose number equals the start selector, while the start-interrupt enable is 1, gives a one-cycle xfer_start on the next cycle. The same gating as R3 applies. A non-matching number, or any event while the enable is 0, gives no start.
- R6: An event whose number equals the abort selector, while the abort-interrupt enable is 1, gives a one-cycle xfer_abort on the next cycle and sets abort_flag. While the enable is 0, that event has no effect.
- R7: With the pattern-abort enable set, pat_match gives a one-cycle xfer_abort together with a one-cycle en_clr_req, and leaves abort_flag unchanged. With the enable clear, pat_match is ignored.
- R8: When any abort condition and any start condition occur in the same cycle, only xfer_abort is issued.
- R9: A start condition seen while ch_en is 0 or eng_busy is 1 is dropped. No start appears later when the condition lifts.
- R10: abort_flag stays 1 until a cycle with flag_clr high. If a flag-setting abort and flag_clr coincide, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word, strobes read as 0 |
| irq_vld | input | 1 | Interrupt event valid, one cycle per event |
| irq_num | input | 8 | Interrupt number of the event |
| ch_en | input | 1 | Channel enable from the channel control |
| eng_busy | input | 1 | Transfer engine has a transfer in progress |
| pat_match | input | 1 | Datapath pattern-match indication |
| flag_clr | input | 1 | Clears the sticky abort flag |
| xfer_start | output | 1 | One-cycle start request to the engine |
| xfer_abort | output | 1 | One-cycle abort request to the engine |
| en_clr_req | output | 1 | One-cycle request to clear the channel enable |
| abort_flag | output | 1 | Sticky interrupt-abort flag |

## Verification
A wrong selector or enable bit shows at reg_rdata on the cycle after the write. It also shows on the first matching event, as a missing or extra start or abort pulse exactly one edge later. A broken priority or gating term shows as a start pulse that sits next to an abort, or that follows a cycle with eng_busy or ch_en low. A flag that fails to hold shows at abort_flag in any idle cycle after an interrupt abort.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int DATA_W   = 32;
  localparam int IRQ_W    = 8;

  // control-word bit positions (software decodes these)
  localparam int AB_LSB    = 16;
  localparam int ST_LSB    = 8;
  localparam int FORCE_BIT = 7;
  localparam int KILL_BIT  = 6;
  localparam int PATEN_BIT = 5;
  localparam int STEN_BIT  = 4;
  localparam int ABEN_BIT  = 3;

  localparam int AB_MSB    = AB_LSB + IRQ_W - 1;
  localparam int ST_MSB    = ST_LSB + IRQ_W - 1;
  localparam int NSEL      = 2;   // selector 0 = start, 1 = abort
  localparam int SEL_START = 0;
  localparam int SEL_ABORT = 1;

  typedef struct packed {
    logic [IRQ_W-1:0] ab_sel;
    logic [IRQ_W-1:0] st_sel;
    logic             pat_en;
    logic             st_en;
    logic             ab_en;
  } evt_cfg_t;

  localparam logic [IRQ_W-1:0] SEL_RST = {IRQ_W{1'b1}};
endpackage

// File: rtl/dma_evt_regs.sv
module dma_evt_regs
  import dma_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output evt_cfg_t          cfg,
  output logic              sw_force,
  output logic              sw_kill
);
  evt_cfg_t cfg_q;
  logic     unused_wbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.ab_sel <= SEL_RST;
      cfg_q.st_sel <= SEL_RST;
      cfg_q.pat_en <= 1'b0;
      cfg_q.st_en  <= 1'b0;
      cfg_q.ab_en  <= 1'b0;
    end else if (reg_we) begin
      cfg_q.ab_sel <= reg_wdata[AB_MSB:AB_LSB];
      cfg_q.st_sel <= reg_wdata[ST_MSB:ST_LSB];
      cfg_q.pat_en <= reg_wdata[PATEN_BIT];
      cfg_q.st_en  <= reg_wdata[STEN_BIT];
      cfg_q.ab_en  <= reg_wdata[ABEN_BIT];
    end
  end

  // strobes live only for the write cycle; they are never stored
  assign sw_force = reg_we & reg_wdata[FORCE_BIT];
  assign sw_kill  = reg_we & reg_wdata[KILL_BIT];

  always_comb begin
    reg_rdata = '0;
    reg_rdata[AB_MSB:AB_LSB] = cfg_q.ab_sel;
    reg_rdata[ST_MSB:ST_LSB] = cfg_q.st_sel;
    reg_rdata[PATEN_BIT]     = cfg_q.pat_en;
    reg_rdata[STEN_BIT]      = cfg_q.st_en;
    reg_rdata[ABEN_BIT]      = cfg_q.ab_en;
  end

  assign cfg = cfg_q;
  assign unused_wbits = ^{reg_wdata[DATA_W-1:AB_MSB+1], reg_wdata[ABEN_BIT-1:0]};
endmodule

// File: rtl/dma_evt_match.sv
module dma_evt_match
  import dma_evt_pkg::*;
(
  input  logic                  irq_vld,
  input  logic [IRQ_W-1:0]      irq_num,
  input  logic [NSEL-1:0][IRQ_W-1:0] sel,
  input  logic [NSEL-1:0]       sel_en,
  output logic [NSEL-1:0]       hit
);
  for (genvar g = 0; g < NSEL; g++) begin : g_cmp
    assign hit[g] = irq_vld & sel_en[g] & (irq_num == sel[g]);
  end
endmodule

// File: rtl/dma_evt_arb.sv
module dma_evt_arb (
  input  logic clk,
  input  logic rst,
  input  logic start_hit,
  input  logic abort_hit,
  input  logic sw_force,
  input  logic sw_kill,
  input  logic pat_abort,
  input  logic ch_en,
  input  logic eng_busy,
  input  logic flag_clr,
  output logic xfer_start,
  output logic xfer_abort,
  output logic en_clr_req,
  output logic abort_flag
);
  logic any_abort;
  logic start_ok;

  assign any_abort = abort_hit | sw_kill | pat_abort;
  assign start_ok  = (start_hit | sw_force) & ch_en & ~eng_busy & ~any_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_start <= 1'b0;
      xfer_abort <= 1'b0;
      en_clr_req <= 1'b0;
      abort_flag <= 1'b0;
    end else begin
      xfer_start <= start_ok;
      xfer_abort <= any_abort;
      en_clr_req <= pat_abort;
      if (abort_hit)     abort_flag <= 1'b1;
      else if (flag_clr) abort_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_evt_ctrl.sv
module dma_evt_ctrl
  import dma_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_vld,
  input  logic [IRQ_W-1:0]  irq_num,
  input  logic              ch_en,
  input  logic              eng_busy,
  input  logic              pat_match,
  input  logic              flag_clr,
  output logic              xfer_start,
  output logic              xfer_abort,
  output logic              en_clr_req,
  output logic              abort_flag
);
  evt_cfg_t                    cfg;
  logic                        sw_force, sw_kill;
  logic [NSEL-1:0][IRQ_W-1:0]  sel;
  logic [NSEL-1:0]             sel_en;
  logic [NSEL-1:0]             hit;

  dma_evt_regs u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg(cfg), .sw_force(sw_force), .sw_kill(sw_kill)
  );

  assign sel[SEL_START]    = cfg.st_sel;
  assign sel[SEL_ABORT]    = cfg.ab_sel;
  assign sel_en[SEL_START] = cfg.st_en;
  assign sel_en[SEL_ABORT] = cfg.ab_en;

  dma_evt_match u_match (
    .irq_vld(irq_vld), .irq_num(irq_num), .sel(sel), .sel_en(sel_en), .hit(hit)
  );

  dma_evt_arb u_arb (
    .clk(clk), .rst(rst),
    .start_hit(hit[SEL_START]), .abort_hit(hit[SEL_ABORT]),
    .sw_force(sw_force), .sw_kill(sw_kill),
    .pat_abort(cfg.pat_en & pat_match),
    .ch_en(ch_en), .eng_busy(eng_busy), .flag_clr(flag_clr),
    .xfer_start(xfer_start), .xfer_abort(xfer_abort),
    .en_clr_req(en_clr_req), .abort_flag(abort_flag)
  );
endmodule

// File: rtl/dma_evt_chk.sv
module dma_evt_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] reg_rdata,
  input logic        irq_vld,
  input logic        ch_en,
  input logic        eng_busy,
  input logic        flag_clr,
  input logic        xfer_start,
  input logic        xfer_abort,
  input logic        en_clr_req,
  input logic        abort_flag
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[31:24] == 8'h00) && (reg_rdata[2:0] == 3'b000));

  a_r3_strobes_read_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7:6] == 2'b00);

  a_r7_enclr_with_abort: assert property (@(posedge clk) disable iff (rst)
    en_clr_req |-> xfer_abort);

  a_r8_abort_wins: assert property (@(posedge clk) disable iff (rst)
    xfer_abort |-> !xfer_start);

  a_r9_start_needs_en: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> ($past(ch_en) && !$past(eng_busy)));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (abort_flag && !flag_clr) |=> abort_flag);

  a_r6_flag_from_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_flag) |-> ($past(irq_vld) && xfer_abort));
endmodule

bind dma_evt_ctrl dma_evt_chk u_chk (.*);

// File: tb/sim_dma_evt_ctrl.sv
`timescale 1ns/1ps
module sim_dma_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_vld = 1'b0;
  logic [7:0]  irq_num = '0;
  logic        ch_en = 1'b1;
  logic        eng_busy = 1'b0;
  logic        pat_match = 1'b0;
  logic        flag_clr = 1'b0;
  logic        xfer_start, xfer_abort, en_clr_req, abort_flag;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dma_evt_ctrl u0 (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // outputs packed as {start, abort, en_clr, flag}
  function automatic logic [31:0] outs();
    return {28'd0, xfer_start, xfer_abort, en_clr_req, abort_flag};
  endfunction

  task automatic wr(logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic irq(logic [7:0] n);
    irq_vld = 1'b1; irq_num = n;
    tick();
    irq_vld = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 32'h00FF_FF00);
    chk("R1 outputs", outs(), 32'h0);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF);
    chk("R2 all-ones readback", reg_rdata, 32'h00FF_FF38);
    chk("R8 force+kill gives abort only", outs(), 32'h4);
    wr(32'h5AA5_5A07);
    chk("R2 pattern readback", reg_rdata, 32'h00A5_5A00);
    tick();
    chk("R2 outputs idle", outs(), 32'h0);
  endtask

  task automatic t_sw();
    wr(32'h0042_2180);
    chk("R3 force start", outs(), 32'h8);
    chk("R3 force reads 0", reg_rdata, 32'h0042_2100);
    tick();
    chk("R3 single cycle", outs(), 32'h0);
    wr(32'h0042_2140);
    chk("R4 kill aborts, flag kept", outs(), 32'h4);
    chk("R4 kill reads 0", reg_rdata, 32'h0042_2100);
    tick();
    chk("R4 single cycle", outs(), 32'h0);
  endtask

  task automatic t_irq_start();
    wr(32'h0042_2110);
    irq(8'h21);
    chk("R5 start on match", outs(), 32'h8);
    tick();
    chk("R5 single cycle", outs(), 32'h0);
    irq(8'h22);
    chk("R5 no start on mismatch", outs(), 32'h0);
    irq(8'h42);
    chk("R6 abort num ignored while disabled", outs(), 32'h0);
    wr(32'h0042_2100);
    irq(8'h21);
    chk("R5 ignored when disabled", outs(), 32'h0);
  endtask

  task automatic t_irq_abort();
    wr(32'h0042_2108);
    irq(8'h42);
    chk("R6 abort and flag", outs(), 32'h5);
    tick(); tick(); tick();
    chk("R10 flag holds", outs(), 32'h1);
    clear_flag();
    chk("R10 flag cleared", outs(), 32'h0);
    flag_clr = 1'b1;
    irq(8'h42);
    flag_clr = 1'b0;
    chk("R10 set wins over clear", outs(), 32'h5);
    clear_flag();
    wr(32'h0042_2100);
    irq(8'h42);
    chk("R6 ignored when disabled", outs(), 32'h0);
  endtask

  task automatic t_priority();
    wr(32'h0033_3318);
    irq(8'h33);
    chk("R8 same irq both enabled", outs(), 32'h5);
    clear_flag();
    wr(32'h0033_3320);
    pat_match = 1'b1;
    wr(32'h0033_33A0);
    pat_match = 1'b0;
    chk("R8 pattern beats force", outs(), 32'h6);
  endtask

  task automatic t_pattern();
    wr(32'h0000_0020);
    pat_match = 1'b1; tick(); pat_match = 1'b0;
    chk("R7 pattern abort + en clear", outs(), 32'h6);
    tick();
    chk("R7 single cycle", outs(), 32'h0);
    wr(32'h0000_0000);
    pat_match = 1'b1; tick(); pat_match = 1'b0;
    chk("R7 ignored when disabled", outs(), 32'h0);
  endtask

  task automatic t_gating();
    wr(32'h0000_1110);
    ch_en = 1'b0;
    irq(8'h11);
    chk("R9 no start while disabled", outs(), 32'h0);
    ch_en = 1'b1;
    tick();
    chk("R9 not queued after enable", outs(), 32'h0);
    eng_busy = 1'b1;
    wr(32'h0000_1190);
    chk("R9 no force while busy", outs(), 32'h0);
    eng_busy = 1'b0;
    tick(); tick();
    chk("R9 not queued after busy", outs(), 32'h0);
    eng_busy = 1'b1;
    wr(32'h0000_1150);
    chk("R4 kill works while busy", outs(), 32'h4);
    eng_busy = 1'b0;
    irq(8'h11);
    chk("R5 start when idle again", outs(), 32'h8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_layout();
    t_sw();
    t_irq_start();
    t_irq_abort();
    t_priority();
    t_pattern();
    t_gating();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule